// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block is the arithmetic engine behind an accumulator machine's byte multiply and byte divide. It takes two unsigned bytes, the accumulator operand `a_i` and the second-register operand `b_i`. It either multiplies them or divides the first by the second. The results come back as a new value for each register, together with a carry flag and an overflow flag. Register storage and instruction decode sit outside the block. The surrounding core samples `a_o`, `b_o`, `cy_o` and `ov_o` in the cycle that `done_o` pulses.

A request is accepted on a clock edge where `start_i` is high and no operation is in flight. Internally the unit retires two operand bits per clock. Multiply uses shift-and-add and divide uses restoring division. With the default 8-bit width, every operation therefore takes exactly four clocks, whatever the operand values. The first iteration works straight from the input pins, so no separate load cycle is needed. The result registers keep their values until the next operation completes.

Top module: `muldiv_unit`

## Requirements
- R1: With `op_i` = 0 (multiply), `a_o` holds bits 7..0 and `b_o` holds bits 15..8 of the unsigned product `a_i` × `b_i` (for example 0x50 × 0xA0 gives `b_o` = 0x32 and `a_o` = 0x00).
- R2: After a multiply, `ov_o` is 1 exactly when the product is greater than 0xFF, and 0 otherwise.
- R3: `cy_o` is 0 after every completed operation, whether multiply or divide.
- R4: With `op_i` = 1 (divide) and `b_i` ≠ 0, `a_o` is the integer quotient `a_i` / `b_i`, `b_o` is the remainder, and `ov_o` is 0 (for example 251 / 18 gives 13 remainder 17).
- R5: A divide by `b_i` = 0 sets `ov_o` to 1, returns `a_o` = 0xFF, and returns `b_o` equal to the original `a_i`.
- R6: `done_o` is high for exactly one clock. That clock is the fourth clock after the edge that accepted `start_i`, and `done_o` is low in the three clocks before it.
- R7: A `start_i` that arrives while an operation is in flight is ignored. It changes neither the result of the running operation nor the timing of `done_o`, and it causes no later `done_o`.
- R8: A `start_i` that is high in the cycle where `done_o` is high is accepted, so operations can run back to back with no idle clock.
- R9: While `rst_ni` is low, `a_o`, `b_o`, `cy_o`, `ov_o` and `done_o` are all 0.
- R10: `a_o`, `b_o`, `cy_o` and `ov_o` change only in a cycle where `done_o` is high. They hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one machine cycle per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation; taken only when the unit is idle |
| op_i | input | 1 | Operation select: 0 = multiply, 1 = divide |
| a_i | input | 8 | Accumulator operand (multiplier or dividend) |
| b_i | input | 8 | Second operand (multiplicand or divisor) |
| a_o | output | 8 | New accumulator value: product low byte or quotient |
| b_o | output | 8 | New second-register value: product high byte or remainder |
| cy_o | output | 1 | Carry flag result, always cleared |
| ov_o | output | 1 | Overflow flag: wide product or zero divisor |
| done_o | output | 1 | One-cycle pulse marking valid results |

## Verification
The checker assumes that `op_i`, `a_i` and `b_i` are known values in every cycle where `start_i` could be accepted. It captures them only at that edge and treats them as irrelevant at all other times. It also assumes that reset is applied from time zero, so its own acceptance model starts in step with the unit. The bench drives all inputs on the falling clock edge and keeps them at defined values at all times. In one directed test it changes the operands and `op_i` on purpose in the middle of an operation. This shows that only the values at the accepting edge matter.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

endpackage

// File: rtl/md_mul_step.sv
// One multiply iteration: adds BPC shifted copies of the multiplicand,
// selected by the next BPC multiplier bits, into the running product.
module md_mul_step #(
    parameter int W   = 8,
    parameter int BPC = 2,
    parameter int IW  = 2
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [BPC-1:0] bits_i,
    input  logic [IW-1:0]  idx_i,
    output logic [2*W-1:0] acc_o
);

    logic [2*W-1:0] ext;

    always_comb begin
        ext   = {{W{1'b0}}, mcand_i};
        acc_o = acc_i;
        for (int j = 0; j < BPC; j++) begin
            if (bits_i[j]) begin
                acc_o = acc_o + (ext << (int'(idx_i) * BPC + j));
            end
        end
    end

endmodule

// File: rtl/md_div_step.sv
// One divide iteration: BPC chained restoring-division bit steps.
// The quotient bits shift into the low end of the dividend register.
module md_div_step #(
    parameter int W   = 8,
    parameter int BPC = 2
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] dsr_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] num_o
);

    logic [W-1:0] rem_c [BPC+1];
    logic [W-1:0] num_c [BPC+1];

    assign rem_c[0] = rem_i;
    assign num_c[0] = num_i;

    for (genvar j = 0; j < BPC; j++) begin : g_bit
        logic [W:0] trial;
        logic       fits;
        assign trial        = {rem_c[j], num_c[j][W-1]};
        assign fits         = (trial >= {1'b0, dsr_i});
        assign rem_c[j+1]   = fits ? W'(trial - {1'b0, dsr_i}) : trial[W-1:0];
        assign num_c[j+1]   = {num_c[j][W-2:0], fits};
    end

    assign rem_o = rem_c[BPC];
    assign num_o = num_c[BPC];

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int W   = 8,
    parameter int BPC = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic         cy_o,
    output logic         ov_o,
    output logic         done_o
);
    import muldiv_pkg::*;

    localparam int CYC = W / BPC;
    localparam int IW  = (CYC > 1) ? $clog2(CYC) : 1;

    typedef struct packed {
        logic           busy;
        md_op_e         op;
        logic [IW-1:0]  cnt;
        logic [2*W-1:0] acc;
        logic [W-1:0]   mq;
        logic [W-1:0]   rem;
        logic [W-1:0]   opb;
        logic [W-1:0]   a_res;
        logic [W-1:0]   b_res;
        logic           cy;
        logic           ov;
        logic           done;
    } md_state_t;

    md_state_t st_d, st_q;

    logic           first;
    md_op_e         cur_op;
    logic [W-1:0]   cur_mq, cur_b, cur_rem;
    logic [2*W-1:0] cur_acc;
    logic [IW-1:0]  cur_idx;
    logic [2*W-1:0] mul_acc;
    logic [W-1:0]   div_rem, div_num;

    // The first iteration runs on the pins; later ones on the registers.
    assign first   = start_i && !st_q.busy;
    assign cur_op  = first ? md_op_e'(op_i) : st_q.op;
    assign cur_mq  = first ? a_i : st_q.mq;
    assign cur_b   = first ? b_i : st_q.opb;
    assign cur_acc = first ? '0  : st_q.acc;
    assign cur_rem = first ? '0  : st_q.rem;
    assign cur_idx = first ? '0  : st_q.cnt;

    md_mul_step #(.W(W), .BPC(BPC), .IW(IW)) u_mul (
        .acc_i   (cur_acc),
        .mcand_i (cur_b),
        .bits_i  (cur_mq[BPC-1:0]),
        .idx_i   (cur_idx),
        .acc_o   (mul_acc)
    );

    md_div_step #(.W(W), .BPC(BPC)) u_div (
        .rem_i (cur_rem),
        .num_i (cur_mq),
        .dsr_i (cur_b),
        .rem_o (div_rem),
        .num_o (div_num)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (first || st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.op   = cur_op;
            st_d.opb  = cur_b;
            st_d.cnt  = cur_idx + 1'b1;
            if (cur_op == OP_MUL) begin
                st_d.acc = mul_acc;
                st_d.mq  = cur_mq >> BPC;
            end else begin
                st_d.rem = div_rem;
                st_d.mq  = div_num;
            end
            if (cur_idx == IW'(CYC - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cy   = 1'b0;
                if (cur_op == OP_MUL) begin
                    st_d.a_res = mul_acc[W-1:0];
                    st_d.b_res = mul_acc[2*W-1:W];
                    st_d.ov    = |mul_acc[2*W-1:W];
                end else begin
                    // A zero divisor makes every trial subtraction fit, which
                    // yields an all-ones quotient and the dividend as remainder.
                    st_d.a_res = div_num;
                    st_d.b_res = div_rem;
                    st_d.ov    = (cur_b == '0);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_o    = st_q.a_res;
    assign b_o    = st_q.b_res;
    assign cy_o   = st_q.cy;
    assign ov_o   = st_q.ov;
    assign done_o = st_q.done;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int W   = 8,
    parameter int BPC = 2
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         start_i,
    input logic         op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] a_o,
    input logic [W-1:0] b_o,
    input logic         cy_o,
    input logic         ov_o,
    input logic         done_o
);

    localparam int CYC = W / BPC;
    localparam int CNW = $clog2(CYC + 1);

    logic           c_busy;
    logic [CNW-1:0] c_cnt;
    logic           c_op;
    logic [W-1:0]   c_a, c_b;
    logic           c_end;
    logic           c_accept;
    logic [2*W-1:0] c_prod;
    logic [2*W-1:0] c_recon;

    assign c_end    = c_busy && (c_cnt == CNW'(CYC));
    assign c_accept = start_i && (!c_busy || c_end);
    assign c_prod   = {{W{1'b0}}, c_a} * {{W{1'b0}}, c_b};
    assign c_recon  = {{W{1'b0}}, a_o} * {{W{1'b0}}, c_b} + {{W{1'b0}}, b_o};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_busy <= 1'b0;
            c_cnt  <= '0;
            c_op   <= 1'b0;
            c_a    <= '0;
            c_b    <= '0;
        end else if (c_accept) begin
            c_busy <= 1'b1;
            c_cnt  <= CNW'(1);
            c_op   <= op_i;
            c_a    <= a_i;
            c_b    <= b_i;
        end else if (c_end) begin
            c_busy <= 1'b0;
        end else if (c_busy) begin
            c_cnt  <= c_cnt + 1'b1;
        end
    end

    a_r1_mul_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !c_op) |-> ({b_o, a_o} == c_prod));

    a_r2_mul_ov: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !c_op) |-> (ov_o == (c_prod > {{W{1'b0}}, {W{1'b1}}})));

    a_r3_cy_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !cy_o);

    a_r4_div_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && c_op && (c_b != '0)) |->
            ((c_recon == {{W{1'b0}}, c_a}) && (b_o < c_b) && !ov_o));

    a_r5_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && c_op && (c_b == '0)) |->
            (ov_o && (a_o == {W{1'b1}}) && (b_o == c_a)));

    a_r6_done_when_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c_end |-> done_o);

    a_r7_no_stray_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> c_end);

    a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> !done_o);

    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(a_o) && $stable(b_o) && $stable(cy_o) && $stable(ov_o)));

endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W), .BPC(BPC)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .a_o     (a_o),
    .b_o     (b_o),
    .cy_o    (cy_o),
    .ov_o    (ov_o),
    .done_o  (done_o)
);

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       start_i = 1'b0;
    logic       op_i = 1'b0;
    logic [7:0] a_i = 8'h00;
    logic [7:0] b_i = 8'h00;
    logic [7:0] a_o, b_o;
    logic       cy_o, ov_o, done_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5ns clk_i = ~clk_i;

    muldiv_unit i_muldiv_unit (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .a_o     (a_o),
        .b_o     (b_o),
        .cy_o    (cy_o),
        .ov_o    (ov_o),
        .done_o  (done_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge of the done cycle.
    task automatic run(input bit op, input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        logic [7:0]  ea, eb;
        logic        eov;
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk_i);
        start_i = 1'b0;
        for (int c = 1; c < 4; c++) begin
            check(done_o == 1'b0, "R6 done early", int'(done_o), 0);
            @(negedge clk_i);
        end
        if (!op) begin
            p   = {8'h00, a} * {8'h00, b};
            ea  = p[7:0];
            eb  = p[15:8];
            eov = (p > 16'h00FF);
            check(a_o == ea, "R1 product low", int'(a_o), int'(ea));
            check(b_o == eb, "R1 product high", int'(b_o), int'(eb));
            check(ov_o == eov, "R2 mul ov", int'(ov_o), int'(eov));
        end else if (b != 8'h00) begin
            ea = a / b;
            eb = a % b;
            check(a_o == ea, "R4 quotient", int'(a_o), int'(ea));
            check(b_o == eb, "R4 remainder", int'(b_o), int'(eb));
            check(ov_o == 1'b0, "R4 div ov", int'(ov_o), 0);
        end else begin
            check(a_o == 8'hFF, "R5 zero-div A", int'(a_o), 'hFF);
            check(b_o == a, "R5 zero-div B", int'(b_o), int'(a));
            check(ov_o == 1'b1, "R5 zero-div ov", int'(ov_o), 1);
        end
        check(done_o == 1'b1, "R6 R8 done in fourth cycle", int'(done_o), 1);
        check(cy_o == 1'b0, "R3 carry", int'(cy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check({a_o, b_o, cy_o, ov_o, done_o} == '0, "R9 reset state",
              int'({a_o, b_o, cy_o, ov_o, done_o}), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // Required values: 0x50 * 0xA0 and 251 / 18 (R1, R2, R4).
        run(1'b0, 8'h50, 8'hA0);
        run(1'b1, 8'd251, 8'd18);

        // R10: results hold while idle, and done is a single pulse (R6).
        for (int c = 0; c < 4; c++) begin
            @(negedge clk_i);
            check(done_o == 1'b0, "R6 pulse width", int'(done_o), 1'b0);
            check(a_o == 8'd13 && b_o == 8'd17, "R10 hold",
                  int'({a_o, b_o}), int'({8'd13, 8'd17}));
        end

        // R7: a second start in mid-operation is ignored.
        start_i = 1'b1; op_i = 1'b0; a_i = 8'd3; b_i = 8'd5;
        @(negedge clk_i);
        start_i = 1'b0;
        @(negedge clk_i);
        start_i = 1'b1; op_i = 1'b1; a_i = 8'd200; b_i = 8'd7;
        @(negedge clk_i);
        start_i = 1'b0;
        check(done_o == 1'b0, "R7 no early done", int'(done_o), 0);
        @(negedge clk_i);
        check(done_o == 1'b1, "R7 done on time", int'(done_o), 1);
        check(a_o == 8'd15 && b_o == 8'd0, "R7 first result kept",
              int'({a_o, b_o}), int'({8'd15, 8'd0}));
        for (int c = 0; c < 4; c++) begin
            @(negedge clk_i);
            check(done_o == 1'b0, "R7 no second done", int'(done_o), 0);
            check(a_o == 8'd15, "R7 R10 result unchanged", int'(a_o), 15);
        end

        // Sweep: every A against a spread of B values, back to back (R8).
        for (int op = 0; op < 2; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int bl = 0; bl < 32; bl++) begin
                    int b;
                    b = (bl < 16) ? bl : (bl - 16) * 16 + 15;
                    run(op[0], a[7:0], b[7:0]);
                end
            end
        end
        start_i = 1'b0;
        @(negedge clk_i);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule